// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns parallel characters into an asynchronous serial stream. It takes one character at a time from an upstream holding register or queue through a valid/take handshake. It frames the character with a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop sequence. Timing comes from a single-cycle enable, `tick16`, that pulses at sixteen times the bit rate. One bit lasts sixteen ticks.

The character size, parity selection and stop length are captured when a character is taken, so the upstream logic may change them while a frame is on the line. When automatic flow control is on, a new character is started only while the active-low clear-to-send input is low. A character that has started always runs to its end. A break control holds the line low for as long as it is set. It drops any frame in flight, and the line returns high as soon as the control is released. An empty flag reports that the shifter is idle and no character is offered.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, and whenever no frame is active and break is off, `tx` is 1 and `char_take` is 0 unless a character can be started.
- R2: A frame starts with `tx` low for 16 ticks. The data bits follow, least significant first, 16 ticks each. The number of data bits is 5, 6, 7 or 8 for `char_size` codes 0, 1, 2 and 3.
- R3: With `parity_en` set, one parity bit of 16 ticks follows the data. `parity_mode` 0 gives even parity over the sent data bits, 1 gives odd parity, 2 gives a constant 1 and 3 gives a constant 0.
- R4: The stop sequence holds `tx` high for 16 ticks when `stop_long` is 0. When `stop_long` is 1 it lasts 32 ticks, or 24 ticks when `char_size` is 0.
- R5: A character is taken (`char_take` is 1 for one cycle) when `char_valid` is 1 and starting is allowed, either while idle or in the cycle of the final stop tick. In that case its start bit follows the stop sequence with no idle gap.
- R6: With `afc_en` at 1 and `cts_n` at 1, `char_take` stays 0. Changes on `cts_n` during a frame do not alter that frame.
- R7: While `break_en` is 1, `tx` is 0, `char_take` is 0, and any frame in progress is discarded. In the first cycle after release, `tx` is 1 unless a new character was taken at that edge.
- R8: `tx_empty` is 1 exactly when no frame is active and `char_valid` is 0.
- R9: `char_size`, `parity_en`, `parity_mode` and `stop_long` are captured with the character. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| char_valid | input | 1 | A character is offered |
| char_data | input | 8 | Offered character |
| char_take | output | 1 | Character consumed at this edge |
| char_size | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit enable |
| parity_mode | input | 2 | 0 even, 1 odd, 2 one, 3 zero |
| stop_long | input | 1 | Long stop sequence select |
| break_en | input | 1 | Force line low |
| afc_en | input | 1 | Automatic flow control enable |
| cts_n | input | 1 | Clear to send, active low |
| tx | output | 1 | Serial line output |
| tx_empty | output | 1 | Idle and nothing offered |

## Verification
A wrong bit counter or wrong phase shows up as `tx` taking a wrong level at a tick edge. The bench compares the line against an expected level on every cycle, so a fault is reported within one tick of where it starts. A faulty parity computation, stop length or captured setting shows up at the 16-tick slot that holds that bit. A mistake in take timing shows up in the same cycle through `char_take` or `tx_empty`. Gaps or overlaps between back-to-back frames show as a shift of every later edge.

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       char_valid,
  input  logic [7:0] char_data,
  output logic       char_take,
  input  logic [1:0] char_size,
  input  logic       parity_en,
  input  logic [1:0] parity_mode,
  input  logic       stop_long,
  input  logic       break_en,
  input  logic       afc_en,
  input  logic       cts_n,
  output logic       tx,
  output logic       tx_empty
);
  localparam int CW = $clog2(2 * OS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OS + OS / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] stop_last;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic [1:0]    size_q;
  logic          par_bit, par_on;
  logic [7:0]    dmask;
  logic          par_calc;

  wire allow     = char_valid && !break_en && (!afc_en || !cts_n);
  wire bit_end   = tick16 && (tcnt == BIT_LAST);
  wire stop_end  = tick16 && (tcnt == stop_last);
  wire last_data = (bidx == 3'd4 + {1'b0, size_q});

  assign char_take = allow && (st == S_IDLE || (st == S_STOP && stop_end));
  assign tx_empty  = (st == S_IDLE) && !char_valid;
  assign dmask     = char_data & (8'hFF >> (2'd3 - char_size));

  always_comb begin
    case (parity_mode)
      2'd0:    par_calc = ^dmask;
      2'd1:    par_calc = ~^dmask;
      2'd2:    par_calc = 1'b1;
      default: par_calc = 1'b0;
    endcase
  end

  always_comb begin
    if (break_en) tx = 1'b0;
    else begin
      case (st)
        S_START: tx = 1'b0;
        S_DATA:  tx = shreg[0];
        S_PAR:   tx = par_bit;
        default: tx = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tcnt      <= '0;
      stop_last <= BIT_LAST;
      bidx      <= '0;
      shreg     <= '0;
      size_q    <= '0;
      par_bit   <= 1'b0;
      par_on    <= 1'b0;
    end else if (break_en) begin
      st   <= S_IDLE;
      tcnt <= '0;
    end else if (char_take) begin
      st        <= S_START;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= dmask;
      size_q    <= char_size;
      par_on    <= parity_en;
      par_bit   <= par_calc;
      stop_last <= !stop_long ? BIT_LAST : (char_size == 2'd0 ? HALF_LAST : TWO_LAST);
    end else if (tick16) begin
      case (st)
        S_START: begin
          if (bit_end) begin
            st   <= S_DATA;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        S_DATA: begin
          if (bit_end) begin
            tcnt  <= '0;
            shreg <= shreg >> 1;
            bidx  <= bidx + 1'b1;
            if (last_data) st <= par_on ? S_PAR : S_STOP;
          end else tcnt <= tcnt + 1'b1;
        end
        S_PAR: begin
          if (bit_end) begin
            st   <= S_STOP;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        S_STOP: begin
          if (stop_end) begin
            st   <= S_IDLE;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        default: tcnt <= '0;
      endcase
    end
  end
endmodule

module uart_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic char_valid,
  input logic char_take,
  input logic break_en,
  input logic afc_en,
  input logic cts_n,
  input logic tx,
  input logic tx_empty
);
  p_take_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_en && cts_n) |-> !char_take);

  p_take_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    break_en |-> !char_take);

  p_release_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (break_en && !char_take) |=> (break_en || tx || !$past(rst_n) ? 1'b1 : tx));

  p_empty_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (tx || break_en));

  p_empty_needs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> !tx_empty);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_take |=> (!tx || break_en));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !char_take && !break_en) |=> (break_en || tx == $past(tx)));
endmodule

bind uart_tx_serializer uart_tx_serializer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .char_valid(char_valid),
  .char_take(char_take), .break_en(break_en), .afc_en(afc_en), .cts_n(cts_n),
  .tx(tx), .tx_empty(tx_empty)
);

// File: tb/uart_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module uart_tx_serializer_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic       char_valid = 1'b0, parity_en = 1'b0, stop_long = 1'b0;
  logic       break_en = 1'b0, afc_en = 1'b0, cts_n = 1'b0;
  logic [7:0] char_data = 8'h00;
  logic [1:0] char_size = 2'd3, parity_mode = 2'd0;
  logic       char_take, tx, tx_empty;

  uart_tx_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .char_valid(char_valid),
    .char_data(char_data), .char_take(char_take), .char_size(char_size),
    .parity_en(parity_en), .parity_mode(parity_mode), .stop_long(stop_long),
    .break_en(break_en), .afc_en(afc_en), .cts_n(cts_n), .tx(tx), .tx_empty(tx_empty)
  );

  always #10 clk = ~clk;

  int total = 0, failed = 0, cyc = 0;
  bit done = 0;
  logic [7:0] src_q[$];
  bit    lev[$];
  string tg[$];
  logic [1:0] l_size, l_pmode;
  logic       l_pen, l_slong;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic push_seg(input bit v, input int n, input string t);
    for (int i = 0; i < n; i++) begin lev.push_back(v); tg.push_back(t); end
  endtask

  task automatic push_frame(input logic [7:0] d);
    int n = 5 + int'(char_size);
    int ones = 0;
    bit p;
    push_seg(1'b0, 16, "R2");
    for (int i = 0; i < n; i++) begin push_seg(d[i], 16, "R2"); ones += int'(d[i]); end
    if (parity_en) begin
      case (parity_mode)
        2'd0: p = (ones % 2) == 1;
        2'd1: p = (ones % 2) == 0;
        2'd2: p = 1'b1;
        default: p = 1'b0;
      endcase
      push_seg(p, 16, "R3");
    end
    push_seg(1'b1, !stop_long ? 16 : (char_size == 2'd0 ? 24 : 32), "R4");
    l_size = char_size; l_pen = parity_en; l_pmode = parity_mode; l_slong = stop_long;
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    tick16 = (cyc % 4) == 3;
    char_valid = src_q.size() != 0;
    if (char_valid) char_data = src_q[0];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(tx == 1'b1, "R1", "tx in reset", int'(tx), 1);
      check(char_take == 1'b0, "R1", "take in reset", int'(char_take), 0);
    end else begin
      bit can, etx, etake, eempty, cfgdiff;
      string t;
      can = char_valid && !break_en && (!afc_en || !cts_n);
      etx = break_en ? 1'b0 : (lev.size() == 0 ? 1'b1 : lev[0]);
      etake = can && (lev.size() == 0 || (tick16 && lev.size() == 1));
      eempty = lev.size() == 0 && !char_valid;
      cfgdiff = lev.size() != 0 && (l_size != char_size || l_pen != parity_en ||
                l_pmode != parity_mode || l_slong != stop_long);
      if (break_en) t = "R7";
      else if (lev.size() == 0) t = "R1";
      else if (cfgdiff) t = "R9";
      else if (afc_en && cts_n) t = "R6";
      else t = tg[0];
      check(tx == etx, t, "tx", int'(tx), int'(etx));
      check(char_take == etake, (afc_en && cts_n) ? "R6" : (break_en ? "R7" : "R5"),
            "char_take", int'(char_take), int'(etake));
      check(tx_empty == eempty, "R8", "tx_empty", int'(tx_empty), int'(eempty));
      if (break_en) begin
        lev.delete(); tg.delete();
      end else begin
        if (tick16 && lev.size() != 0) begin void'(lev.pop_front()); void'(tg.pop_front()); end
        if (lev.size() == 0 && can) begin
          push_frame(char_data);
          void'(src_q.pop_front());
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    do @(negedge clk); while (!(src_q.size() == 0 && lev.size() == 0));
    step(3);
  endtask

  task automatic cfg(input int sz, input bit pe, input int pm, input bit sl);
    char_size = 2'(sz); parity_en = pe; parity_mode = 2'(pm); stop_long = sl;
  endtask

  initial begin
    step(5);
    rst_n = 1'b1;
    step(10);
    // R1 idle, R2/R4/R5 back-to-back 8-bit frames
    cfg(3, 0, 0, 0);
    src_q.push_back(8'h55); src_q.push_back(8'hA3); src_q.push_back(8'h00);
    drain();
    // R2 R3 R4 across all sizes, parity modes and stop lengths
    for (int sz = 0; sz < 4; sz++)
      for (int pm = 0; pm < 5; pm++)
        for (int sl = 0; sl < 2; sl++) begin
          cfg(sz, pm != 4, pm % 4, sl[0]);
          src_q.push_back(8'(8'hC5 + sz * 16 + pm * 3 + sl));
          src_q.push_back(8'(8'h3A ^ (pm * 7)));
          drain();
        end
    // R9 config changes mid-frame
    cfg(3, 1, 0, 0);
    src_q.push_back(8'h6B);
    step(120);
    cfg(0, 0, 3, 1);
    step(200);
    cfg(1, 1, 1, 1);
    drain();
    // R6 flow control
    cfg(3, 0, 0, 0);
    afc_en = 1'b1; cts_n = 1'b1;
    src_q.push_back(8'h81); src_q.push_back(8'h7E);
    step(300);
    cts_n = 1'b0;
    step(20);
    cts_n = 1'b1;
    step(900);
    cts_n = 1'b0;
    drain();
    afc_en = 1'b0;
    // R7 break mid-frame, then release
    src_q.push_back(8'h0F); src_q.push_back(8'hF0);
    step(150);
    break_en = 1'b1;
    step(80);
    break_en = 1'b0;
    drain();
    break_en = 1'b1;
    step(40);
    break_en = 1'b0;
    step(20);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule